// File: doc/BRIEF.md
# Channel and Die Select Address Dehasher

This block takes a 64-bit address whose channel-select and die-select bits were scrambled by an XOR hash, and recovers their plain values. A request carries the address, the number of interleaved channels (8, 16 or 32), the number of interleaved dies (1, 2 or 4) and a five-bit vector of hash enables, one each for the 4K, 64K, 2M, 1G and 1T hash granules. Each select bit has its own set of higher address bits. A select bit is inverted when the XOR of its enabled terms is one.

The block is a small sequencer that corrects one select bit per clock. All channel bits are corrected first and then the die bits. Each correction sees the address as left by the ones before it. A request is taken through a valid/ready handshake only while the block is idle. The result is announced by a single-cycle done pulse and is held until the next request is taken. An unsupported channel or die count is reported through an error flag, and the address is returned untouched.

Top module: `chan_die_unhash`

## Requirements
- R1: The number of channel corrections is log2 of the channel count. Channel step i rewrites address bit 8+i for i = 0..3 and bit 14 for i = 4. Each correction cycle changes at most one address bit.
- R2: For channel step i, the hash terms are bit 15+i under the 64K enable, bit 22+i under the 2M enable, bit 29+i under the 1G enable, and both bits 36+i and 43+i under the 1T enable.
- R3: The 4K term, address bit 12+i, is part of channel step i only for i = 0, 1 and 2. It is never part of channel step 3 or 4, nor of any die step.
- R4: The number of die corrections is log2 of the die count. Die step i rewrites bit 12+i using bit 20+i (64K), 27+i (2M), 34+i (1G) and 41+i (1T).
- R5: Every channel step completes before the first die step. Each step reads the address as already modified by the earlier steps.
- R6: A request with C channel steps and D die steps raises out_valid in the (C+D+1)-th cycle after the accepting edge. out_valid lasts exactly one cycle.
- R7: in_ready is high only while idle. While busy, in_valid and new input values have no effect on the result being produced.
- R8: The supported counts are a channel count of 8, 16 or 32 and a die count of 1, 2 or 4. Any other value sets out_err, returns in_addr unchanged, and raises out_valid in the first cycle after acceptance. A supported request clears out_err.
- R9: After reset, in_ready is 1, out_valid is 0 and out_err is 0.
- R10: The enable vector maps bit 0 to 4K, bit 1 to 64K, bit 2 to 2M, bit 3 to 1G and bit 4 to 1T. With all enables clear, the address is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request will be taken |
| in_addr | input | 64 | Hashed address |
| in_chan_cnt | input | 6 | Interleaved channel count (8, 16, 32) |
| in_die_cnt | input | 3 | Interleaved die count (1, 2, 4) |
| in_hash_en | input | 5 | Hash enables: [0] 4K, [1] 64K, [2] 2M, [3] 1G, [4] 1T |
| out_valid | output | 1 | One-cycle done pulse |
| out_addr | output | 64 | Dehashed address, held until next request |
| out_err | output | 1 | Unsupported channel or die count |

## Verification
The assertions check the following on every cycle:
- the done pulse is never longer than one cycle;
- no request is taken in the cycle after an acceptance;
- a correction cycle never changes more than one address bit;
- the step counter stays inside the programmed step count;
- an unsupported count yields an errored, unchanged address on the next cycle.

The values of the recovered bits can only be shown by the bench's scenarios, which sweep every supported count pair against every enable pattern. These scenarios cover the bit-14 jump of the fifth channel step, the 4K term being limited to the first three steps, the paired 1T terms, and the channel-before-die ordering. They also check the exact latency and that input changes made while busy have no effect.

// File: rtl/unhash_pkg.sv
package unhash_pkg;

   // enable slot order inside the hash enable vector
   localparam int EN_W     = 5;
   localparam int EN_4K    = 0;
   localparam int EN_64K   = 1;
   localparam int EN_2M    = 2;
   localparam int EN_1G    = 3;
   localparam int EN_1T    = 4;

   // per-step term vector: one slot per enable plus a second 1T slot
   localparam int TERM_W   = 6;

   // channel step bit offsets
   localparam int CH_TGT_BASE  = 8;
   localparam int CH_TGT_JUMP  = 14;
   localparam int CH_JUMP_IDX  = 4;
   localparam int CH_4K_BASE   = 12;
   localparam int CH_4K_STEPS  = 3;
   localparam int CH_64K_BASE  = 15;
   localparam int CH_2M_BASE   = 22;
   localparam int CH_1G_BASE   = 29;
   localparam int CH_1TA_BASE  = 36;
   localparam int CH_1TB_BASE  = 43;

   // die step bit offsets
   localparam int DIE_TGT_BASE = 12;
   localparam int DIE_64K_BASE = 20;
   localparam int DIE_2M_BASE  = 27;
   localparam int DIE_1G_BASE  = 34;
   localparam int DIE_1T_BASE  = 41;

   // highest address bit any term of the largest configuration reads
   localparam int TOP_TERM_BIT = 47;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

   function automatic int chan_target(input int idx);
      return (idx == CH_JUMP_IDX) ? CH_TGT_JUMP : CH_TGT_BASE + idx;
   endfunction

   function automatic int die_target(input int idx);
      return DIE_TGT_BASE + idx;
   endfunction

endpackage

// File: rtl/unhash_cnt_decode.sv
module unhash_cnt_decode #(
   parameter int CNT_W   = 6,
   parameter int LOG_MIN = 3,
   parameter int LOG_MAX = 5,
   localparam int LW     = (LOG_MAX < 1) ? 1 : $clog2(LOG_MAX + 1)
) (
   input  logic [CNT_W-1:0] cnt,
   output logic [LW-1:0]    lg,
   output logic             bad
);

   if (LOG_MAX >= CNT_W) begin : g_range_chk
      $error("unhash_cnt_decode: LOG_MAX does not fit in CNT_W");
   end
   if (LOG_MIN > LOG_MAX) begin : g_order_chk
      $error("unhash_cnt_decode: LOG_MIN above LOG_MAX");
   end

   always_comb begin
      bad = 1'b1;
      lg  = '0;
      for (int k = LOG_MIN; k <= LOG_MAX; k++) begin
         if (cnt == CNT_W'(1 << k)) begin
            bad = 1'b0;
            lg  = LW'(k);
         end
      end
   end

endmodule

// File: rtl/unhash_bit.sv
module unhash_bit
   import unhash_pkg::*;
#(
   parameter bit HAS_4K  = 1'b1,
   parameter bit HAS_1TB = 1'b1
) (
   input  logic [TERM_W-1:0] term_v,
   input  logic [EN_W-1:0]   en,
   output logic              flip
);

   logic [TERM_W-1:0] gate_v;
   logic              unused_in;

   if (HAS_4K) begin : g_with_4k
      assign gate_v[0] = en[EN_4K];
   end else begin : g_no_4k
      assign gate_v[0] = 1'b0;
   end

   assign gate_v[1] = en[EN_64K];
   assign gate_v[2] = en[EN_2M];
   assign gate_v[3] = en[EN_1G];
   assign gate_v[4] = en[EN_1T];

   if (HAS_1TB) begin : g_with_1tb
      assign gate_v[5] = en[EN_1T];
   end else begin : g_no_1tb
      assign gate_v[5] = 1'b0;
   end

   assign flip      = ^(term_v & gate_v);
   assign unused_in = ^{term_v, en};

endmodule

// File: rtl/unhash_terms.sv
module unhash_terms
   import unhash_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int CH_MAX  = 5,
   parameter int DIE_MAX = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [EN_W-1:0]    en,
   output logic [CH_MAX-1:0]  chan_flip,
   output logic [DIE_MAX-1:0] die_flip
);

   logic unused_addr;
   assign unused_addr = ^addr;

   for (genvar gi = 0; gi < CH_MAX; gi++) begin : g_chan
      logic [TERM_W-1:0] tv;
      if (gi < CH_4K_STEPS) begin : g_4k
         assign tv[0] = addr[CH_4K_BASE + gi];
      end else begin : g_no4k
         assign tv[0] = 1'b0;
      end
      assign tv[1] = addr[CH_64K_BASE + gi];
      assign tv[2] = addr[CH_2M_BASE  + gi];
      assign tv[3] = addr[CH_1G_BASE  + gi];
      assign tv[4] = addr[CH_1TA_BASE + gi];
      assign tv[5] = addr[CH_1TB_BASE + gi];

      unhash_bit #(
         .HAS_4K  (gi < CH_4K_STEPS),
         .HAS_1TB (1'b1)
      ) u_bit (
         .term_v (tv),
         .en     (en),
         .flip   (chan_flip[gi])
      );
   end

   for (genvar gj = 0; gj < DIE_MAX; gj++) begin : g_die
      logic [TERM_W-1:0] tv;
      assign tv[0] = 1'b0;
      assign tv[1] = addr[DIE_64K_BASE + gj];
      assign tv[2] = addr[DIE_2M_BASE  + gj];
      assign tv[3] = addr[DIE_1G_BASE  + gj];
      assign tv[4] = addr[DIE_1T_BASE  + gj];
      assign tv[5] = 1'b0;

      unhash_bit #(
         .HAS_4K  (1'b0),
         .HAS_1TB (1'b0)
      ) u_bit (
         .term_v (tv),
         .en     (en),
         .flip   (die_flip[gj])
      );
   end

endmodule

// File: rtl/unhash_seq.sv
module unhash_seq
   import unhash_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int CH_MAX  = 5,
   parameter int DIE_MAX = 2,
   parameter int CH_LW   = 3,
   parameter int DIE_LW  = 2,
   localparam int STEP_W = $clog2(CH_MAX + DIE_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic               cfg_bad,
   input  logic [CH_LW-1:0]   nchan_in,
   input  logic [DIE_LW-1:0]  ndie_in,
   input  logic [EN_W-1:0]    en_in,
   input  logic [CH_MAX-1:0]  chan_flip,
   input  logic [DIE_MAX-1:0] die_flip,
   output logic [EN_W-1:0]    en_q,
   output logic [ADDR_W-1:0]  addr_q,
   output logic               out_valid,
   output logic               out_err
);

   seq_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] nch_q;
   logic [STEP_W-1:0] ndi_q;
   logic [STEP_W-1:0] tot_q;
   logic [ADDR_W-1:0] mask;
   logic              last_step;

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_DONE);
   assign last_step = (step_q == tot_q - STEP_W'(1));

   // one-hot correction mask for the step in progress
   always_comb begin
      mask = '0;
      for (int i = 0; i < CH_MAX; i++) begin
         if (step_q == STEP_W'(i) && STEP_W'(i) < nch_q)
            mask[chan_target(i)] = chan_flip[i];
      end
      for (int j = 0; j < DIE_MAX; j++) begin
         if (step_q == STEP_W'(j) + nch_q && STEP_W'(j) < ndi_q)
            mask[die_target(j)] = die_flip[j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         en_q    <= '0;
         step_q  <= '0;
         nch_q   <= '0;
         ndi_q   <= '0;
         tot_q   <= '0;
         out_err <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  addr_q  <= in_addr;
                  en_q    <= en_in;
                  step_q  <= '0;
                  nch_q   <= STEP_W'(nchan_in);
                  ndi_q   <= STEP_W'(ndie_in);
                  tot_q   <= STEP_W'(nchan_in) + STEP_W'(ndie_in);
                  out_err <= cfg_bad;
                  state_q <= cfg_bad ? ST_DONE : ST_RUN;
               end
            end
            ST_RUN: begin
               addr_q <= addr_q ^ mask;
               step_q <= step_q + STEP_W'(1);
               if (last_step)
                  state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R7
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R1
   one_bit_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> ($countones(addr_q ^ $past(addr_q)) <= 1));

   // R6
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (step_q < tot_q));

endmodule

// File: rtl/chan_die_unhash.sv
module chan_die_unhash
   import unhash_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int CH_CNT_W    = 6,
   parameter int DIE_CNT_W   = 3,
   parameter int CH_LOG_MIN  = 3,
   parameter int CH_MAX      = 5,
   parameter int DIE_MAX     = 2,
   localparam int CH_LW      = $clog2(CH_MAX + 1),
   localparam int DIE_LW     = (DIE_MAX < 1) ? 1 : $clog2(DIE_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [ADDR_W-1:0]    in_addr,
   input  logic [CH_CNT_W-1:0]  in_chan_cnt,
   input  logic [DIE_CNT_W-1:0] in_die_cnt,
   input  logic [EN_W-1:0]      in_hash_en,
   output logic                 out_valid,
   output logic [ADDR_W-1:0]    out_addr,
   output logic                 out_err
);

   if (ADDR_W <= TOP_TERM_BIT) begin : g_addr_chk
      $error("chan_die_unhash: ADDR_W too narrow for the hash terms");
   end
   if (CH_MAX > CH_JUMP_IDX + 1 || CH_MAX < 1) begin : g_ch_chk
      $error("chan_die_unhash: CH_MAX outside the defined channel steps");
   end
   if (DIE_MAX > 2 || DIE_MAX < 1) begin : g_die_chk
      $error("chan_die_unhash: DIE_MAX outside the defined die steps");
   end

   logic [CH_LW-1:0]   nchan;
   logic [DIE_LW-1:0]  ndie;
   logic               chan_bad;
   logic               die_bad;
   logic               cfg_bad;
   logic [EN_W-1:0]    en_q;
   logic [CH_MAX-1:0]  chan_flip;
   logic [DIE_MAX-1:0] die_flip;

   unhash_cnt_decode #(
      .CNT_W   (CH_CNT_W),
      .LOG_MIN (CH_LOG_MIN),
      .LOG_MAX (CH_MAX)
   ) u_chan_dec (
      .cnt (in_chan_cnt),
      .lg  (nchan),
      .bad (chan_bad)
   );

   unhash_cnt_decode #(
      .CNT_W   (DIE_CNT_W),
      .LOG_MIN (0),
      .LOG_MAX (DIE_MAX)
   ) u_die_dec (
      .cnt (in_die_cnt),
      .lg  (ndie),
      .bad (die_bad)
   );

   assign cfg_bad = chan_bad | die_bad;

   unhash_terms #(
      .ADDR_W  (ADDR_W),
      .CH_MAX  (CH_MAX),
      .DIE_MAX (DIE_MAX)
   ) u_terms (
      .addr      (out_addr),
      .en        (en_q),
      .chan_flip (chan_flip),
      .die_flip  (die_flip)
   );

   unhash_seq #(
      .ADDR_W  (ADDR_W),
      .CH_MAX  (CH_MAX),
      .DIE_MAX (DIE_MAX),
      .CH_LW   (CH_LW),
      .DIE_LW  (DIE_LW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_addr   (in_addr),
      .cfg_bad   (cfg_bad),
      .nchan_in  (nchan),
      .ndie_in   (ndie),
      .en_in     (in_hash_en),
      .chan_flip (chan_flip),
      .die_flip  (die_flip),
      .en_q      (en_q),
      .addr_q    (out_addr),
      .out_valid (out_valid),
      .out_err   (out_err)
   );

   // R8
   bad_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cfg_bad) |=>
         (out_valid && out_err && out_addr == $past(in_addr)));

endmodule

// File: tb/chan_die_unhash_test.sv
`timescale 1ns/1ps
module chan_die_unhash_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_addr = '0;
   logic [5:0]  in_chan_cnt = 6'd8;
   logic [2:0]  in_die_cnt = 3'd1;
   logic [4:0]  in_hash_en = '0;
   logic        out_valid;
   logic [63:0] out_addr;
   logic        out_err;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   chan_die_unhash uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_addr     (in_addr),
      .in_chan_cnt (in_chan_cnt),
      .in_die_cnt  (in_die_cnt),
      .in_hash_en  (in_hash_en),
      .out_valid   (out_valid),
      .out_addr    (out_addr),
      .out_err     (out_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic int chan_log(input logic [5:0] c);
      case (c)
         6'd8:    return 3;
         6'd16:   return 4;
         6'd32:   return 5;
         default: return -1;
      endcase
   endfunction

   function automatic int die_log(input logic [2:0] d);
      case (d)
         3'd1:    return 0;
         3'd2:    return 1;
         3'd4:    return 2;
         default: return -1;
      endcase
   endfunction

   // reference dehash written from the requirement text
   function automatic logic [63:0] model(input logic [63:0] a, input int nc,
                                         input int nd, input logic [4:0] en);
      logic [63:0] r = a;
      if (nc < 0 || nd < 0) return a;
      for (int i = 0; i < nc; i++) begin
         int  tgt = (i == 4) ? 14 : 8 + i;
         logic h = 1'b0;
         if (en[0] && i < 3) h ^= r[12 + i];
         if (en[1]) h ^= r[15 + i];
         if (en[2]) h ^= r[22 + i];
         if (en[3]) h ^= r[29 + i];
         if (en[4]) h ^= r[36 + i] ^ r[43 + i];
         r[tgt] ^= h;
      end
      for (int i = 0; i < nd; i++) begin
         logic h = 1'b0;
         if (en[1]) h ^= r[20 + i];
         if (en[2]) h ^= r[27 + i];
         if (en[3]) h ^= r[34 + i];
         if (en[4]) h ^= r[41 + i];
         r[12 + i] ^= h;
      end
      return r;
   endfunction

   // drive one request on a negedge while idle, hold junk during busy
   task automatic run_tx(input logic [63:0] a, input logic [5:0] ch,
                         input logic [2:0] di, input logic [4:0] en,
                         input string req);
      int nc = chan_log(ch);
      int nd = die_log(di);
      bit is_bad = (nc < 0) || (nd < 0);
      logic [63:0] exp = model(a, nc, nd, en);
      int exp_lat = is_bad ? 1 : nc + nd + 1;
      int lat = 0;
      bit busy_ok = 1'b1;
      in_valid    = 1'b1;
      in_addr     = a;
      in_chan_cnt = ch;
      in_die_cnt  = di;
      in_hash_en  = en;
      @(posedge clk);
      @(negedge clk);
      lat = 1;
      // R7: new values during busy must not be taken
      in_addr     = ~a;
      in_hash_en  = ~en;
      in_chan_cnt = 6'd16;
      in_die_cnt  = 3'd2;
      while (!out_valid && lat < 40) begin
         if (in_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      in_valid = 1'b0;
      chk(busy_ok, "R7", "in_ready while busy", 64'(busy_ok), 64'd1);
      chk(lat == exp_lat, "R6", "latency", 64'(lat), 64'(exp_lat));
      chk(out_addr == exp, req, "out_addr", out_addr, exp);
      chk(out_err == is_bad, "R8", "out_err", 64'(out_err), 64'(is_bad));
      @(negedge clk);
      chk(!out_valid && in_ready, "R6", "pulse width/idle",
          64'({out_valid, in_ready}), 64'b01);
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      logic [5:0] chs [3] = '{6'd8, 6'd16, 6'd32};
      logic [2:0] dis [3] = '{3'd1, 3'd2, 3'd4};
      repeat (3) @(negedge clk);
      // R9
      chk(in_ready == 1'b1, "R9", "reset in_ready", 64'(in_ready), 64'd1);
      chk(out_valid == 1'b0, "R9", "reset out_valid", 64'(out_valid), 64'd0);
      chk(out_err == 1'b0, "R9", "reset out_err", 64'(out_err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: no enables leaves the address alone
      run_tx(64'hFFFF_FFFF_FFFF_FFFF, 6'd32, 3'd4, 5'b00000, "R10");
      run_tx(64'h0123_4567_89AB_CDEF, 6'd8, 3'd1, 5'b00000, "R10");

      // R3: only the 4K term set, bits 12..16 high
      run_tx(64'h0000_0000_0001_F000, 6'd32, 3'd1, 5'b00001, "R3");
      // R1: fifth channel step targets bit 14 (64K term bit 19)
      run_tx(64'h0000_0000_0008_0000, 6'd32, 3'd1, 5'b00010, "R1");
      // R2: paired 1T terms cancel when both set
      run_tx(64'h0000_0810_0000_0000, 6'd8, 3'd1, 5'b10000, "R2");
      // R4: die step from 1G term bit 34
      run_tx(64'h0000_0004_0000_0000, 6'd8, 3'd2, 5'b01000, "R4");
      // R5: channel 2 uses 4K bit 14, die 0 then flips bit 12
      run_tx(64'h0000_0000_0010_5000, 6'd8, 3'd2, 5'b00011, "R5");

      // sweep of all supported counts against all enable patterns
      for (int ci = 0; ci < 3; ci++)
         for (int di = 0; di < 3; di++)
            for (int e = 0; e < 32; e++)
               for (int rep = 0; rep < 2; rep++)
                  run_tx({$urandom(), $urandom()}, chs[ci], dis[di], 5'(e),
                         "R2");

      // R8: unsupported counts
      run_tx(64'hDEAD_BEEF_0BAD_F00D, 6'd4,  3'd1, 5'b11111, "R8");
      run_tx(64'h1234_5678_9ABC_DEF0, 6'd0,  3'd2, 5'b11111, "R8");
      run_tx(64'hCAFE_0000_FFFF_1111, 6'd63, 3'd1, 5'b11111, "R8");
      run_tx(64'h0F0F_F0F0_0F0F_F0F0, 6'd16, 3'd3, 5'b11111, "R8");
      run_tx(64'hAAAA_5555_AAAA_5555, 6'd32, 3'd0, 5'b11111, "R8");
      run_tx(64'h5555_AAAA_5555_AAAA, 6'd24, 3'd7, 5'b11111, "R8");
      // R8: a supported request afterwards clears the error
      run_tx(64'hFFFF_FFFF_FFFF_FFFF, 6'd16, 3'd4, 5'b11111, "R8");

      finish_run();
   end

endmodule